// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast clock by a programmable ratio N = P*B + A. It does this by steering a dual-modulus prescaler rather than by running one wide divide-by-N counter. A swallow count A holds the prescaler at modulus P+1 for the first A prescaler periods of each sequence. For the remaining B-A periods the prescaler divides by P. A main count B counts prescaler periods and marks the end of each sequence. At that end both counts reload and a one-cycle comparison pulse is emitted. A phase detector uses that pulse as its feedback edge.

A one-bit select picks the modulus pair: the wide pair P_WIDE/P_WIDE+1 (64/65 by default) or the narrow pair P_NARROW/P_NARROW+1 (32/33 by default). The swallow field is AW bits wide, and only its low AW-1 bits count. The main field is BW bits wide. New settings are captured on a load strobe and wait for the next sequence boundary, so a sequence in progress is never cut short. Every part is synchronous logic clocked by the fast clock.

Top module: `swallow_div`

## Requirements
- R1: While the settings are unchanged, successive rising edges of `cmp_pulse` are exactly N = P*B + A clock cycles apart. A is the swallow field with its top bit cleared.
- R2: With `narrow_sel` = 0, P = P_WIDE. With `narrow_sel` = 1, P = P_NARROW.
- R3: Within each sequence, `mod_sel` is high for exactly A*(P+1) clock cycles. These are the first cycles of the sequence, and `mod_sel` falls only on a prescaler period boundary.
- R4: With A = 0, `mod_sel` stays low for the whole sequence and the period is P*B.
- R5: The top bit of `swallow_in` (bit AW-1) has no effect on the period or on `mod_sel`.
- R6: `cmp_pulse` is high for exactly one cycle, and that cycle is the first cycle of a new sequence.
- R7: Values captured on `load` take effect only at the next sequence boundary. The sequence in progress still ends after the old N cycles, and the following sequence uses the new N.
- R8: While `rst` is high, the block loads its settings and counts directly from the inputs and drives `cmp_pulse` low. The cycle in which `rst` is released is the first cycle of a sequence, and `mod_sel` in that cycle is high exactly when A is not 0.
- R9: If `load` is pulsed more than once within one sequence, the last captured values are the ones applied at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; loads settings from inputs |
| load | input | 1 | Capture strobe for the three setting inputs |
| swallow_in | input | AW | Swallow count A; bit AW-1 ignored |
| main_in | input | BW | Main count B, 3 to 2^BW-1 |
| narrow_sel | input | 1 | 0 selects the wide modulus pair, 1 the narrow pair |
| cmp_pulse | output | 1 | One-cycle pulse once every N clock cycles |
| mod_sel | output | 1 | Prescaler modulus control, high selects P+1 |

## Verification
Some properties are checked by assertions on every cycle:
- `cmp_pulse` is one cycle wide and coincides with freshly reloaded counts.
- The prescaler count stays within the active modulus.
- `mod_sel` only falls on a prescaler boundary and never rises while the active swallow count is zero.
- The active settings change only in the boundary cycle.

The exact period P*B + A, the A*(P+1) cycles spent at the high modulus, and the effect of the narrow select can only be shown by the bench scenarios. The same holds for the old sequence finishing before a load applies, for last-load-wins, and for the ignored top swallow bit. The bench sweeps main counts, all legal swallow counts and both modulus pairs on a reduced configuration.

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int AW       = 7,
  parameter int BW       = 11,
  parameter int P_WIDE   = 64,
  parameter int P_NARROW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] swallow_in,
  input  logic [BW-1:0] main_in,
  input  logic          narrow_sel,
  output logic          cmp_pulse,
  output logic          mod_sel
);
  localparam int PW = $clog2(P_WIDE + 2);
  localparam logic [AW-1:0] A_MASK = {1'b0, {(AW-1){1'b1}}};

  logic [AW-1:0] act_a, pend_a, sw_cnt;
  logic [BW-1:0] act_b, pend_b, b_cnt;
  logic          act_pre, pend_pre, pend_vld;
  logic [PW-1:0] pc;

  wire [AW-1:0] a_clean = swallow_in & A_MASK;
  wire [PW-1:0] p_base  = act_pre ? PW'(P_NARROW) : PW'(P_WIDE);
  wire [PW-1:0] p_last  = mod_sel ? p_base : p_base - PW'(1);
  wire          tick    = (pc == p_last);
  wire          term    = tick && (b_cnt == BW'(1));

  wire [AW-1:0] nxt_a   = pend_vld ? pend_a   : act_a;
  wire [BW-1:0] nxt_b   = pend_vld ? pend_b   : act_b;
  wire          nxt_pre = pend_vld ? pend_pre : act_pre;

  assign mod_sel = |sw_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_a     <= a_clean;
      act_b     <= main_in;
      act_pre   <= narrow_sel;
      pend_a    <= a_clean;
      pend_b    <= main_in;
      pend_pre  <= narrow_sel;
      pend_vld  <= 1'b0;
      sw_cnt    <= a_clean;
      b_cnt     <= main_in;
      pc        <= '0;
      cmp_pulse <= 1'b0;
    end else begin
      cmp_pulse <= term;
      if (tick) begin
        pc <= '0;
        if (term) begin
          act_a    <= nxt_a;
          act_b    <= nxt_b;
          act_pre  <= nxt_pre;
          sw_cnt   <= nxt_a;
          b_cnt    <= nxt_b;
          pend_vld <= 1'b0;
        end else begin
          b_cnt <= b_cnt - BW'(1);
          if (mod_sel) sw_cnt <= sw_cnt - AW'(1);
        end
      end else begin
        pc <= pc + PW'(1);
      end
      if (load) begin
        pend_a   <= a_clean;
        pend_b   <= main_in;
        pend_pre <= narrow_sel;
        pend_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
  parameter int AW = 7,
  parameter int BW = 11,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          cmp_pulse,
  input logic          mod_sel,
  input logic [AW-1:0] act_a,
  input logic [BW-1:0] act_b,
  input logic          act_pre,
  input logic [AW-1:0] sw_cnt,
  input logic [BW-1:0] b_cnt,
  input logic [PW-1:0] pc,
  input logic [PW-1:0] p_base
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |=> !cmp_pulse); // R6

  AST_PULSE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |-> (pc == '0 && b_cnt == act_b && sw_cnt == act_a)); // R6

  AST_PC_RANGE: assert property (@(posedge clk) disable iff (rst)
    pc <= p_base); // R2

  AST_MOD_DROP_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(mod_sel)) |-> pc == '0); // R3

  AST_ZERO_SWALLOW: assert property (@(posedge clk) disable iff (rst)
    (act_a == '0) |-> !mod_sel); // R4

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$stable(act_a) || !$stable(act_b) || !$stable(act_pre)))
      |-> cmp_pulse); // R7
endmodule

bind swallow_div swallow_div_chk #(.AW(AW), .BW(BW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cmp_pulse(cmp_pulse), .mod_sel(mod_sel),
  .act_a(act_a), .act_b(act_b), .act_pre(act_pre), .sw_cnt(sw_cnt),
  .b_cnt(b_cnt), .pc(pc), .p_base(p_base)
);

// File: tb/swallow_div_test.sv
`timescale 1ns/1ps
module swallow_div_test;
  localparam int AW = 4, BW = 5, PWIDE = 8, PNAR = 4;
  localparam int LIMIT = 150000;

  logic clk = 0, rst = 1, load = 0, narrow_sel = 0;
  logic [AW-1:0] swallow_in = 0;
  logic [BW-1:0] main_in = 0;
  logic cmp_pulse, mod_sel;

  swallow_div #(.AW(AW), .BW(BW), .P_WIDE(PWIDE), .P_NARROW(PNAR)) uut (
    .clk(clk), .rst(rst), .load(load), .swallow_in(swallow_in),
    .main_in(main_in), .narrow_sel(narrow_sel),
    .cmp_pulse(cmp_pulse), .mod_sel(mod_sel));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int len = 0, hi = 0, last_len = 0, last_hi = 0, pulses = 0, dbl = 0;
  bit mon_on = 0, prev_fp = 0, timed_out = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) if (mon_on) begin
    if (cmp_pulse) begin
      if (prev_fp) dbl++;
      last_len = len; last_hi = hi; pulses++;
      len = 1; hi = mod_sel ? 1 : 0;
    end else begin
      len++; hi += mod_sel ? 1 : 0;
    end
    prev_fp = cmp_pulse;
  end

  function automatic int pval(bit pre);
    return pre ? PNAR : PWIDE;
  endfunction
  function automatic int nval(int a, int b, bit pre);
    return pval(pre) * b + (a & 7);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int target = pulses + 1;
    while (pulses < target && !timed_out) begin
      @(negedge clk); #1;
      if (cyc > LIMIT) timed_out = 1;
    end
  endtask

  task automatic do_load(int a, int b, bit pre);
    @(posedge clk); #1;
    swallow_in = AW'(a); main_in = BW'(b); narrow_sel = pre; load = 1;
    @(posedge clk); #1;
    load = 0;
  endtask

  int cur_n;
  int blist[8] = '{3, 4, 5, 6, 9, 13, 20, 31};

  initial begin
    swallow_in = 2; main_in = 5; narrow_sel = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0; mon_on = 1;
    @(negedge clk); #1;
    check("R8 pulse low at reset release", cmp_pulse, 0);
    check("R8 mod_sel at first cycle", mod_sel, 1);
    wait_pulse();
    check("R8 first period from reset inputs", last_len, nval(2, 5, 1));
    cur_n = nval(2, 5, 1);

    for (int p = 0; p < 2; p++)
      for (int bi = 0; bi < 8; bi++)
        for (int a = 0; a <= 7 && a <= blist[bi]; a++) begin
          if (timed_out) break;
          do_load(a, blist[bi], p[0]);
          wait_pulse();
          check("R7 sequence in progress keeps old N", last_len, cur_n);
          wait_pulse();
          cur_n = nval(a, blist[bi], p[0]);
          check(p[0] ? "R1 period narrow R2" : "R1 period wide R2", last_len, cur_n);
          check("R3 cycles at high modulus", last_hi, a * (pval(p[0]) + 1));
          if (a == 0) check("R4 zero swallow keeps mod_sel low", last_hi, 0);
        end

    do_load(8 + 3, 9, 0);
    wait_pulse(); wait_pulse();
    check("R5 top swallow bit ignored", last_len, nval(3, 9, 0));
    check("R5 top swallow bit high-modulus cycles", last_hi, 3 * (PWIDE + 1));
    cur_n = nval(3, 9, 0);

    do_load(5, 7, 1);
    do_load(1, 10, 0);
    wait_pulse();
    check("R7 old N after double load", last_len, cur_n);
    wait_pulse();
    check("R9 last load wins", last_len, nval(1, 10, 0));
    wait_pulse();
    check("R1 period stable with no load", last_len, nval(1, 10, 0));

    check("R6 pulse never two cycles wide", dbl, 0);
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, LIMIT);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule